// File: doc/BRIEF.md
# Split-Transaction Memory Command Port

This block is the memory-side front end of a requester that issues reads and writes without waiting for earlier reads to complete. Each command is taken in one cycle through a request/wait handshake. A write carries its address and data together. A read carries only its address, and its data comes back later on a separate valid strobe. Accepting a command and delivering read data are two independent events, so several reads can be in flight at once.

Accepted commands are placed in a small in-order queue. A simple backend removes one entry per cycle, writes to or reads from a local word array, and returns read data in the order the reads were taken. A stall input freezes the backend and stands in for refresh or page-change delays. Those delays fill the queue and are pushed back to the requester through the wait signal, which means only "queue full". No command is ever dropped.

Top module: `mem_split_port`

## Requirements
- R1: During and directly after synchronous reset, `wait_req` and `rd_valid` are both low.
- R2: A command is accepted on a rising edge where `cmd_rd` or `cmd_wr` is high and `wait_req` is low. When both strobes are high, the command is a write: the data is stored and no read data is returned for it.
- R3: `wait_req` is high exactly when the queue holds QUEUE_DEPTH entries (4 by default), and the queue never holds more.
- R4: Read data is returned in the order the reads were accepted, with exactly one single-cycle `rd_valid` pulse per accepted read.
- R5: A read returns the value of the most recent earlier-accepted write to the same address, even when the two commands are issued back to back.
- R6: While `stall` is high, no entry leaves the queue, so `rd_valid` is low in the cycle after any cycle with `stall` high.
- R7: A read accepted into an empty queue with `stall` low raises `rd_valid` on the cycle after its accepting edge.
- R8: A command presented while `wait_req` is high is not accepted and has no effect on the stored data or on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_addr | input | ADDR_W | Word address of the command |
| cmd_wdata | input | DATA_W | Data stored by a write |
| cmd_rd | input | 1 | Read strobe |
| cmd_wr | input | 1 | Write strobe (takes priority over the read strobe) |
| stall | input | 1 | Freezes the backend drain while high |
| wait_req | output | 1 | Queue full; the requester holds its command |
| rd_data | output | DATA_W | Returned read data |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` valid |

## Verification
The bench builds the block with a four-entry queue, a 16-bit data path and a 4-bit address. The small address space means random traffic hits the same words again and again, so read-after-write ordering through the queue is exercised constantly. The shallow queue fills after only four stalled commands. This makes the full boundary, a command refused while full, and reads left waiting behind a stalled backend easy to reach. Random stalls also mix reads and writes in every possible queue occupancy.

// File: rtl/msp_pkg.sv
package msp_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } msp_op_e;

  // advance a ring index, wrapping at depth
  function automatic int ring_step(input int idx, input int depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/msp_cmd_queue.sv
module msp_cmd_queue
  import msp_pkg::*;
#(
  parameter int ENTRY_W = 23,
  parameter int DEPTH   = 4,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_entry,
  input  logic               pop,
  output logic [ENTRY_W-1:0] pop_entry,
  output logic               full,
  output logic               empty,
  output logic [CNT_W-1:0]   count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic [PTR_W-1:0]   rd_ptr;
  logic [CNT_W-1:0]   fill;

  always_ff @(posedge clk) begin
    if (push) begin
      slots[wr_ptr] <= push_entry;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) begin
        wr_ptr <= PTR_W'(ring_step(int'(wr_ptr), DEPTH));
      end
      if (pop) begin
        rd_ptr <= PTR_W'(ring_step(int'(rd_ptr), DEPTH));
      end
      case ({push, pop})
        2'b10:   fill <= fill + CNT_W'(1);
        2'b01:   fill <= fill - CNT_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign pop_entry = slots[rd_ptr];
  assign full      = (fill == CNT_W'(DEPTH));
  assign empty     = (fill == '0);
  assign count     = fill;

endmodule

// File: rtl/msp_store.sv
module msp_store
  import msp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  msp_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int WORDS = 2 ** ADDR_W;

  logic [DATA_W-1:0] words [WORDS];

  // single-port word array with a synchronous read
  always_ff @(posedge clk) begin
    if (fire && op == OP_WRITE) begin
      words[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (fire && op == OP_READ) begin
      rdata <= words[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
    end else begin
      rvalid <= fire && (op == OP_READ);
    end
  end

endmodule

// File: rtl/mem_split_port.sv
module mem_split_port
  import msp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              stall,
  output logic              wait_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int ENTRY_W = 1 + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(QUEUE_DEPTH + 1);

  logic               q_push;
  logic               q_pop;
  logic               q_full;
  logic               q_empty;
  logic [CNT_W-1:0]   q_count;
  logic [ENTRY_W-1:0] push_entry;
  logic [ENTRY_W-1:0] head_entry;
  logic               pop_is_wr;
  msp_op_e            head_op;
  logic [ADDR_W-1:0]  head_addr;
  logic [DATA_W-1:0]  head_wdata;

  // front end: accept when a strobe is up and the queue has room
  assign q_push     = (cmd_rd || cmd_wr) && !q_full;
  assign push_entry = {cmd_wr, cmd_addr, cmd_wdata};
  assign wait_req   = q_full;

  msp_cmd_queue #(
    .ENTRY_W (ENTRY_W),
    .DEPTH   (QUEUE_DEPTH),
    .CNT_W   (CNT_W)
  ) u_queue (
    .clk        (clk),
    .rst        (rst),
    .push       (q_push),
    .push_entry (push_entry),
    .pop        (q_pop),
    .pop_entry  (head_entry),
    .full       (q_full),
    .empty      (q_empty),
    .count      (q_count)
  );

  // backend: one entry per cycle unless frozen
  assign q_pop      = !q_empty && !stall;
  assign pop_is_wr  = head_entry[ENTRY_W-1];
  assign head_op    = pop_is_wr ? OP_WRITE : OP_READ;
  assign head_addr  = head_entry[ENTRY_W-2 -: ADDR_W];
  assign head_wdata = head_entry[DATA_W-1:0];

  msp_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .fire   (q_pop),
    .op     (head_op),
    .addr   (head_addr),
    .wdata  (head_wdata),
    .rdata  (rd_data),
    .rvalid (rd_valid)
  );

endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             stall,
  input logic             wait_req,
  input logic             rd_valid,
  input logic             q_push,
  input logic             q_pop,
  input logic             pop_is_wr,
  input logic [CNT_W-1:0] q_count
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    q_count <= CNT_W'(DEPTH)); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wait_req && !q_pop |=> wait_req); // R3

  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (rst)
    q_push && !q_pop |=> q_count == $past(q_count) + CNT_W'(1)); // R2

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stall |=> !rd_valid); // R6

  AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(q_pop && !pop_is_wr)); // R4

  AST_REFUSED_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
    wait_req |=> q_count <= $past(q_count)); // R8

endmodule

bind mem_split_port msp_checker #(
  .DEPTH (QUEUE_DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .wait_req  (wait_req),
  .rd_valid  (rd_valid),
  .q_push    (q_push),
  .q_pop     (q_pop),
  .pop_is_wr (pop_is_wr),
  .q_count   (q_count)
);

// File: tb/mem_split_port_bench.sv
module mem_split_port_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 4;
  localparam int DW         = 16;
  localparam int DEPTH      = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          cmd_rd = 1'b0;
  logic          cmd_wr = 1'b0;
  logic          stall = 1'b0;
  logic          wait_req;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int vectors    = 0;
  int miscompares = 0;
  int valid_seen = 0;
  bit rnd_mode   = 1'b0;
  bit done       = 1'b0;

  logic [DW-1:0] shadow [2**AW];
  logic [DW-1:0] exp_data [$];
  string         exp_tag  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_split_port #(
    .ADDR_W      (AW),
    .DATA_W      (DW),
    .QUEUE_DEPTH (DEPTH)
  ) u_mem_split_port (
    .clk       (clk),
    .rst       (rst),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .cmd_rd    (cmd_rd),
    .cmd_wr    (cmd_wr),
    .stall     (stall),
    .wait_req  (wait_req),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // return monitor: every valid pulse must match the oldest expected read
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      valid_seen++;
      if (exp_data.size() == 0) begin
        check(1'b0, "R4", "rd_valid with no read outstanding", 1, 0);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_data.pop_front();
        t = exp_tag.pop_front();
        check(rd_data == e, t, "returned read data", 32'(rd_data), 32'(e));
      end
    end
  end

  // present a command at a falling edge; returns one cycle after acceptance
  // with the strobes still driven so that commands can follow back to back
  task automatic issue(input bit rd, input bit wr, input int addr,
                       input logic [DW-1:0] data, input string tag);
    cmd_rd    = rd;
    cmd_wr    = wr;
    cmd_addr  = AW'(addr);
    cmd_wdata = data;
    while (wait_req) begin
      @(negedge clk);
      if (rnd_mode) stall = ($urandom_range(0, 3) == 0);
    end
    if (wr) begin
      shadow[addr] = data;
    end else if (rd) begin
      exp_data.push_back(shadow[addr]);
      exp_tag.push_back(tag);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cmd_rd = 1'b0;
    cmd_wr = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    idle();
    stall = 1'b0;
    while ((exp_data.size() != 0 || wait_req) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    repeat (DEPTH + 2) @(negedge clk);
    check(exp_data.size() == 0, "R4", "reads left unreturned", exp_data.size(), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(wait_req == 1'b0, "R1", "wait_req in reset", wait_req, 0);
    check(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(wait_req == 1'b0 && rd_valid == 1'b0, "R1", "outputs after reset",
          {wait_req, rd_valid}, 0);
    for (int i = 0; i < 2**AW; i++) issue(1'b0, 1'b1, i, DW'(16'h0100 + i), "R5");
    drain();
  endtask

  task automatic t_latency();
    issue(1'b0, 1'b1, 3, 16'h1234, "R5");
    drain();
    issue(1'b1, 1'b0, 3, '0, "R7");
    idle();
    check(rd_valid == 1'b0, "R7", "rd_valid one cycle after issue", rd_valid, 0);
    @(negedge clk);
    check(rd_valid == 1'b1, "R7", "rd_valid on cycle after accept", rd_valid, 1);
    drain();
  endtask

  task automatic t_stream();
    int base;
    for (int i = 0; i < 8; i++) issue(1'b0, 1'b1, i, DW'(16'hA000 + 16'(i * 17)), "R5");
    for (int i = 7; i >= 0; i--) issue(1'b1, 1'b0, i, '0, "R4");
    issue(1'b0, 1'b1, 5, 16'hBEEF, "R5");
    issue(1'b1, 1'b0, 5, '0, "R5");
    base = valid_seen;
    drain();
    check(valid_seen - base <= 9, "R4", "pulses after stream", valid_seen - base, 9);
  endtask

  task automatic t_full();
    int base;
    drain();
    base = valid_seen;
    stall = 1'b1;
    issue(1'b0, 1'b1, 8, 16'h0808, "R5");
    issue(1'b0, 1'b1, 9, 16'h0909, "R5");
    issue(1'b1, 1'b0, 8, '0, "R6");
    idle();
    check(wait_req == 1'b0, "R3", "wait_req with three entries", wait_req, 0);
    issue(1'b1, 1'b0, 9, '0, "R6");
    idle();
    check(wait_req == 1'b1, "R3", "wait_req with four entries", wait_req, 1);
    // refused command: shown for one cycle while full, then withdrawn
    cmd_wr = 1'b1;
    cmd_addr = AW'(8);
    cmd_wdata = 16'hDEAD;
    @(negedge clk);
    idle();
    check(wait_req == 1'b1, "R8", "still full after refused write", wait_req, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(rd_valid == 1'b0, "R6", "rd_valid while stalled", rd_valid, 0);
    end
    drain();
    check(valid_seen - base == 2, "R4", "pulses for two reads", valid_seen - base, 2);
    issue(1'b1, 1'b0, 8, '0, "R8");
    drain();
  endtask

  task automatic t_both();
    int base;
    drain();
    base = valid_seen;
    issue(1'b1, 1'b1, 12, 16'h5A5A, "R2");
    drain();
    check(valid_seen == base, "R2", "valid pulses for dual strobe", valid_seen - base, 0);
    issue(1'b1, 1'b0, 12, '0, "R2");
    drain();
    check(valid_seen - base == 1, "R2", "valid pulses after read", valid_seen - base, 1);
  endtask

  task automatic t_random();
    int base;
    int reads = 0;
    drain();
    base = valid_seen;
    rnd_mode = 1'b1;
    for (int n = 0; n < 400; n++) begin
      bit rd;
      stall = ($urandom_range(0, 9) < 4);
      rd = $urandom_range(0, 1) == 1;
      if (rd) reads++;
      issue(rd, !rd, $urandom_range(0, 2**AW - 1), DW'($urandom), "R5");
    end
    rnd_mode = 1'b0;
    drain();
    check(valid_seen - base == reads, "R4", "pulse count under random stall",
          valid_seen - base, reads);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_stream();
    t_full();
    t_both();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule